// File: doc/BRIEF.md
# GPIO Port with Interrupt Control

This block is a 32-pin general-purpose I/O port reached through a simple register bus with an address, a write strobe, write data and a combinational read data return. Software sets the level each pin drives and whether the pin drives at all. It can also read the level actually present on every pin, whatever that pin's direction. All pad inputs pass through a two-flop synchronizer before they are used.

Each pin watches for one of four interrupt conditions, chosen by a 2-bit code: low level, high level, rising edge or falling edge. A detected condition sets a sticky status bit, which software clears by writing a one to it. A mask register chooses which status bits reach the two interrupt outputs, one for pins 0–15 and one for pins 16–31. Reset is asserted asynchronously and released through a two-stage synchronizer. The core therefore comes out of reset on the second clock edge after the reset input rises.

Top module: `gpio_port_irq`

## Requirements
- R1: While reset is active, every register reads 0, `pad_oe` and `pad_out` are 0, and both interrupt outputs are low. Every pin is then an input with its interrupt masked and its condition code 0 (low level).
- R2: Offset 0x00 holds the output data and offset 0x04 holds the direction. Both are read/write. `pad_out` equals the data register and `pad_oe` equals the direction register, with a 1 in the direction register meaning output.
- R3: Offset 0x08 is read-only and returns the pad levels through a two-flop synchronizer. A change on `pad_in` before clock edge k reads back after edge k+1. Writes to this offset change nothing.
- R4: Condition codes are 2 bits per pin. Offset 0x0C holds pins 0–15 and offset 0x10 holds pins 16–31. Pin n's code sits at bits 2*(n mod 16)+1 : 2*(n mod 16). The code values are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge.
- R5: Under a level code, the status bit is set on every clock edge at which the synchronized level matches. After a clear it sets again on the next edge if the level still holds.
- R6: An edge code compares the synchronized level with its sample from one cycle earlier. A pad transition before edge k sets the status bit at edge k+2.
- R7: The status register at offset 0x18 is write-one-to-clear. A 1 in the write data clears that bit, and a 0 leaves it as it was.
- R8: When a condition sets a status bit in the same cycle that software clears it, the bit stays at 1.
- R9: The mask register at offset 0x14 is read/write. `irq_lo` is the OR over pins 0–15 of status AND mask. `irq_hi` is the same OR over pins 16–31.
- R10: Any other offset reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_PINS | Pad levels as seen at the pins |
| pad_out | output | NUM_PINS | Level driven on each pin |
| pad_oe | output | NUM_PINS | Output enable per pin, 1 = drive |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
A corrupted synchronizer stage or a wrong previous sample shows up within three edges as a wrong pad-status read or as a status bit set in the wrong cycle. An edge code that behaves like a level code gives a bit that returns right after a clear. A wrong code-field position makes the wrong pin set its status bit. A lost write-one-to-clear, or a clear that beats a concurrent set, shows at the next read of offset 0x18. It also shows on `irq_lo` or `irq_hi` in the same cycle whenever the bit is unmasked. The bench drives the pads through the port's own outputs for pins set as outputs. It checks every port in every cycle against a cycle model, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register byte offsets (software-visible map)
  localparam int unsigned OFS_DATA  = 32'h00;
  localparam int unsigned OFS_DIR   = 32'h04;
  localparam int unsigned OFS_PADS  = 32'h08;
  localparam int unsigned OFS_CFGLO = 32'h0C;
  localparam int unsigned OFS_CFGHI = 32'h10;
  localparam int unsigned OFS_MASK  = 32'h14;
  localparam int unsigned OFS_STS   = 32'h18;

  // Per-pin interrupt condition code
  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } cond_e;

  localparam int unsigned COND_W = 2;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] stab_q, stab_d;

  always_comb begin
    meta_d = async_in;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
    end
  end

  assign sync_out = stab_q;

endmodule

// File: rtl/gpio_cond_detect.sv
module gpio_cond_detect
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned CFG_W   = NUM_PINS * COND_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl,
  input  logic [CFG_W-1:0]    cfg,
  output logic [NUM_PINS-1:0] hit
);

  logic [NUM_PINS-1:0] prev_q, prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [COND_W-1:0] code;
    assign code = cfg[COND_W*p +: COND_W];

    always_comb begin
      case (cond_e'(code))
        COND_LOW:  hit[p] = ~lvl[p];
        COND_HIGH: hit[p] =  lvl[p];
        COND_RISE: hit[p] =  lvl[p] & ~prev_q[p];
        COND_FALL: hit[p] = ~lvl[p] &  prev_q[p];
        default:   hit[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_sticky_status.sv
module gpio_sticky_status #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] set_vec,
  input  logic [NUM_PINS-1:0] clr_vec,
  output logic [NUM_PINS-1:0] sts
);

  logic [NUM_PINS-1:0] sts_q, sts_d;

  // set has priority over a same-cycle clear
  always_comb begin
    sts_d = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_lo,
  output logic                irq_hi
);

  localparam int unsigned HALF  = NUM_PINS / 2;
  localparam int unsigned CFG_W = NUM_PINS * COND_W;

  logic rst_core_n;

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // ---------------- address decode ----------------
  logic hit_data, hit_dir, hit_pads, hit_cfglo, hit_cfghi, hit_mask, hit_sts;

  always_comb begin
    hit_data  = (bus_addr == ADDR_W'(OFS_DATA));
    hit_dir   = (bus_addr == ADDR_W'(OFS_DIR));
    hit_pads  = (bus_addr == ADDR_W'(OFS_PADS));
    hit_cfglo = (bus_addr == ADDR_W'(OFS_CFGLO));
    hit_cfghi = (bus_addr == ADDR_W'(OFS_CFGHI));
    hit_mask  = (bus_addr == ADDR_W'(OFS_MASK));
    hit_sts   = (bus_addr == ADDR_W'(OFS_STS));
  end

  // ---------------- software registers ----------------
  logic [NUM_PINS-1:0] data_q, data_d;
  logic [NUM_PINS-1:0] dir_q, dir_d;
  logic [NUM_PINS-1:0] cfglo_q, cfglo_d;
  logic [NUM_PINS-1:0] cfghi_q, cfghi_d;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic en_data, en_dir, en_cfglo, en_cfghi, en_mask;

  always_comb begin
    en_data  = bus_wr & hit_data;
    en_dir   = bus_wr & hit_dir;
    en_cfglo = bus_wr & hit_cfglo;
    en_cfghi = bus_wr & hit_cfghi;
    en_mask  = bus_wr & hit_mask;
    data_d   = bus_wdata;
    dir_d    = bus_wdata;
    cfglo_d  = bus_wdata;
    cfghi_d  = bus_wdata;
    mask_d   = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      cfglo_q <= '0;
      cfghi_q <= '0;
      mask_q  <= '0;
    end else begin
      if (en_data)  data_q  <= data_d;
      if (en_dir)   dir_q   <= dir_d;
      if (en_cfglo) cfglo_q <= cfglo_d;
      if (en_cfghi) cfghi_q <= cfghi_d;
      if (en_mask)  mask_q  <= mask_d;
    end
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

  // ---------------- input path and detection ----------------
  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] cond_hit;
  logic [NUM_PINS-1:0] sts_q;
  logic [NUM_PINS-1:0] sts_clr;
  logic [CFG_W-1:0]    cfg_all;

  assign cfg_all = {cfghi_q, cfglo_q};

  gpio_sync #(.WIDTH(NUM_PINS)) u_pad_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_cond_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk   (clk),
    .rst_n (rst_core_n),
    .lvl   (pad_sync),
    .cfg   (cfg_all),
    .hit   (cond_hit)
  );

  assign sts_clr = (bus_wr && hit_sts) ? bus_wdata : '0;

  gpio_sticky_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_vec (cond_hit),
    .clr_vec (sts_clr),
    .sts     (sts_q)
  );

  // ---------------- interrupt outputs ----------------
  logic [NUM_PINS-1:0] pend;

  always_comb begin
    pend   = sts_q & mask_q;
    irq_lo = |pend[HALF-1:0];
    irq_hi = |pend[NUM_PINS-1:HALF];
  end

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      hit_data:  bus_rdata = data_q;
      hit_dir:   bus_rdata = dir_q;
      hit_pads:  bus_rdata = pad_sync;
      hit_cfglo: bus_rdata = cfglo_q;
      hit_cfghi: bus_rdata = cfghi_q;
      hit_mask:  bus_rdata = mask_q;
      hit_sts:   bus_rdata = sts_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned HALF    = NUM_PINS / 2
) (
  input logic                clk,
  input logic                rst_core_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] sts,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq_lo,
  input logic                irq_hi
);

  logic dir_wr, sts_wr;
  assign dir_wr = bus_wr && (bus_addr == ADDR_W'(OFS_DIR));
  assign sts_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STS));

  always @(posedge clk) begin
    if (!rst_core_n) begin
      assert_reset_quiet_R1: assert (pad_oe == '0 && !irq_lo && !irq_hi)
        else $error("R1: outputs active during reset");
    end
  end

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !dir_wr |=> $stable(pad_oe));

  // R7/R8: a status bit only drops when a one was written to it
  assert_sts_drop_w1c_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> ((($past(sts) & ~sts) &
               ~($past(sts_wr) ? $past(bus_wdata) : '0)) == '0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mask == '0) |-> (!irq_lo && !irq_hi));

  assert_irq_hi_half_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((mask[NUM_PINS-1:HALF] & sts[NUM_PINS-1:HALF]) == '0) |-> !irq_hi);

endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .sts        (sts_q),
  .mask       (mask_q),
  .pad_oe     (pad_oe),
  .irq_lo     (irq_lo),
  .irq_hi     (irq_hi)
);

// File: tb/gpio_port_irq_tb.sv
module gpio_port_irq_tb;

  localparam int NP = 32;
  localparam int AW = 8;
  localparam real PERIOD = 8.0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_wr;
  logic [NP-1:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic          irq_lo, irq_hi;

  always #(PERIOD/2) clk = ~clk;

  gpio_port_irq #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // model state
  logic [31:0] m_data, m_dir, m_cfglo, m_cfghi, m_mask, m_sts, m_s1, m_s2, m_prev;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] f_hit(logic [31:0] lv, logic [31:0] pv,
                                        logic [31:0] lo, logic [31:0] hi);
    logic [31:0] h;
    logic [63:0] cf;
    cf = {hi, lo};
    for (int n = 0; n < 32; n++) begin
      case (cf[2*n +: 2])
        2'd0: h[n] = ~lv[n];
        2'd1: h[n] =  lv[n];
        2'd2: h[n] =  lv[n] & ~pv[n];
        default: h[n] = ~lv[n] & pv[n];
      endcase
    end
    return h;
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    case (a)
      8'h00: return m_data;
      8'h04: return m_dir;
      8'h08: return m_s2;
      8'h0C: return m_cfglo;
      8'h10: return m_cfghi;
      8'h14: return m_mask;
      8'h18: return m_sts;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string f_tag(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R2";
      8'h08: return "R3";
      8'h0C, 8'h10: return "R4";
      8'h14: return "R9";
      8'h18: return "R7";
      default: return "R10";
    endcase
  endfunction

  // one cycle: drive, check pre-edge state, advance model across the edge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic [31:0] ext, input string tag);
    logic [31:0] pad, hit, clr, pend;
    @(negedge clk);
    pad = (ext & ~m_dir) | (m_data & m_dir);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; pad_in = pad;
    #1;
    check((tag != "") ? tag : f_tag(a), bus_rdata, f_read(a));
    pend = m_sts & m_mask;
    check("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |pend[15:0]});
    check("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |pend[31:16]});
    check("R2 pad_out", pad_out, m_data);
    check("R2 pad_oe", pad_oe, m_dir);
    hit = f_hit(m_s2, m_prev, m_cfglo, m_cfghi);
    clr = (wr && a == 8'h18) ? wd : 32'h0;
    m_sts = (m_sts & ~clr) | hit;
    if (wr) begin
      case (a)
        8'h00: m_data  = wd;
        8'h04: m_dir   = wd;
        8'h0C: m_cfglo = wd;
        8'h10: m_cfghi = wd;
        8'h14: m_mask  = wd;
        default: ;
      endcase
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};
    logic [31:0] ext;
    void'($urandom(32'h0BADC0DE));
    rst_n = 1'b0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    {m_data, m_dir, m_cfglo, m_cfghi, m_mask, m_sts, m_s1, m_s2, m_prev} = '0;
    repeat (3) @(posedge clk);
    // R1: reset state at every offset
    foreach (addrs[i]) begin
      @(negedge clk);
      bus_addr = addrs[i]; #1;
      check("R1 rdata", bus_rdata, 32'h0);
    end
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 irq", {30'd0, irq_hi, irq_lo}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 data/direction
    step(1, 8'h00, 32'hA5A5_0F0F, 0, "R2");
    step(1, 8'h04, 32'hFFFF_0000, 0, "R2");
    step(0, 8'h00, 0, 0, "R2");
    step(0, 8'h04, 0, 0, "R2");
    // R3 read-only pads, R10 unmapped
    step(1, 8'h08, 32'hFFFF_FFFF, 32'h0000_1234, "R3");
    repeat (3) step(0, 8'h08, 0, 32'h0000_1234, "R3");
    step(1, 8'h1C, 32'hDEAD_BEEF, 32'h0000_1234, "R10");
    step(0, 8'h1C, 0, 32'h0000_1234, "R10");
    // R6 edges: pin0 rise, pin1 fall, others high level
    step(1, 8'h0C, 32'h5555_555E, 0, "R4");
    step(1, 8'h10, 32'h5555_5555, 0, "R4");
    repeat (3) step(0, 8'h00, 0, 32'h0000_0002, "R6");
    step(1, 8'h18, 32'hFFFF_FFFF, 32'h0000_0002, "R7");
    repeat (5) step(0, 8'h18, 0, 32'h0000_0001, "R6");
    step(1, 8'h18, 32'h0000_0003, 32'h0000_0001, "R7");
    repeat (4) step(0, 8'h18, 0, 32'h0000_0001, "R6");
    // R5 level: high level on low pins, pads high
    step(1, 8'h0C, 32'h5555_5555, 32'h0000_00F0, "R4");
    step(1, 8'h18, 32'hFFFF_FFFF, 32'h0000_00F0, "R5");
    repeat (4) step(0, 8'h18, 0, 32'h0000_00F0, "R5");
    // R8 set beats clear: low-level codes, pads low
    step(1, 8'h0C, 32'h0, 0, "R4");
    repeat (3) step(0, 8'h18, 0, 0, "R8");
    step(1, 8'h18, 32'hFFFF_FFFF, 0, "R8");
    step(0, 8'h18, 0, 0, "R8");
    // R9 mask halves
    step(1, 8'h14, 32'h0001_0001, 0, "R9");
    step(0, 8'h18, 0, 0, "R9");
    step(1, 8'h14, 32'h0, 0, "R9");

    // constrained random
    ext = $urandom;
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [7:0] a;
      logic [31:0] wd;
      if ($urandom_range(3) == 0) ext ^= (32'h1 << $urandom_range(31));
      wr = ($urandom_range(9) < 3);
      a  = addrs[$urandom_range(8)];
      wd = $urandom;
      step(wr, a, wd, ext, "");
    end

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule